// File: doc/BRIEF.md
# Pulse-Swallow Feedback Divider

This block divides a fast input clock by a programmable ratio N = B·P + A and emits one single-cycle pulse per output period, meant for the feedback input of a phase detector. It is built from a dual-modulus prescaler model (P or P+1), a main counter loaded with B and a swallow counter loaded with A. While the swallow counter is nonzero the prescaler divides by P+1; for the rest of the B prescaler cycles it divides by P.

Settings arrive on a parallel bus with a load strobe and are held in a pending register. They reach the counters only at the next reload point, which is the end of an output period, or while the hold input is high. Illegal settings are refused and flagged, and the divider keeps its last legal ratio. The hold input keeps all counters at their load state, so phase alignment can be restarted from a known point.

Top module: `pswal_divider`

## Requirements
- R1: With a legal setting active, consecutive `div_pulse` rising edges are exactly B·P + A input clock cycles apart.
- R2: `mod_sel` picks the prescaler base modulus: 0 gives P=8, 1 gives P=16, 2 gives P=32, 3 gives P=64. The alternate modulus is always P+1.
- R3: `div_pulse` is high for exactly one clock cycle per output period.
- R4: The swallow counter stretches exactly A of the B prescaler cycles to P+1. A=0 gives N=B·P, and A=B gives N=B·(P+1).
- R5: A setting loaded while a period is running does not alter that period. It governs every period after the next reload.
- R6: A load with B<3 or B<A is refused. `cfg_err` goes high on the cycle after that load and stays high until a legal load clears it, and the ratio in use stays unchanged.
- R7: While `cnt_hold` is high, no pulse is emitted and the counters sit at their load state with the pending setting. The first pulse appears N cycles after the last clock edge with hold high.
- R8: After reset, `div_pulse` and `cfg_err` are low and the divider runs with B=3, A=0, P=8 (N=24).
- R9: The top of the B range (8191) with A=63 divides correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock being divided |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mod_sel | input | 2 | Prescaler modulus select (0:8/9, 1:16/17, 2:32/33, 3:64/65) |
| b_in | input | 13 | Main counter value B (3..8191) |
| a_in | input | 6 | Swallow counter value A (0..63, not above B) |
| cfg_load | input | 1 | One-cycle strobe capturing mod_sel, b_in, a_in |
| cnt_hold | input | 1 | Synchronous hold of all counters at their load state |
| div_pulse | output | 1 | One-cycle pulse at the end of each output period |
| cfg_err | output | 1 | Last load was refused as illegal |

## Verification
The ratio is measured as the clock count between pulses. It is tried across all four modulus selects, with A=0 and A=B to show whether the swallow counter stretches the right number of prescaler cycles, and with random legal settings to catch errors that depend on the mix of values. A load placed mid-period separates a correct reload point from an early switch to the new ratio, and illegal loads show whether the refusal leaves the running ratio alone. A long hold followed by release, plus a run at the largest B, check the restart alignment and the upper end of the counter widths.

// File: rtl/pswal_pkg.sv
package pswal_pkg;
  localparam int BW       = 13;
  localparam int AW       = 6;
  localparam int SELW     = 2;
  localparam int BASE_LOG = 3;
  localparam int PCW      = BASE_LOG + (1 << SELW);
  localparam logic [BW-1:0] B_MIN = BW'(3);

  typedef struct packed {
    logic [SELW-1:0] sel;
    logic [BW-1:0]   b;
    logic [AW-1:0]   a;
  } ratio_t;

  localparam ratio_t RATIO_RST = '{sel: '0, b: BW'(3), a: '0};

  function automatic logic [PCW-1:0] base_of(logic [SELW-1:0] sel);
    return PCW'(1) << (BASE_LOG + int'(sel));
  endfunction

  function automatic logic ratio_ok(ratio_t r);
    return (r.b >= B_MIN) && (r.b >= {{(BW-AW){1'b0}}, r.a});
  endfunction
endpackage

// File: rtl/pswal_cfg.sv
module pswal_cfg
  import pswal_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   load,
  input  ratio_t req,
  output ratio_t pend,
  output logic   err
);
  ratio_t pend_nx;
  logic   err_nx;
  logic   req_ok;

  always_comb begin
    req_ok  = ratio_ok(req);
    pend_nx = pend;
    err_nx  = err;
    if (load) begin
      if (req_ok) pend_nx = req;
      err_nx = !req_ok;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= RATIO_RST;
      err  <= 1'b0;
    end else begin
      pend <= pend_nx;
      err  <= err_nx;
    end
  end

  // R6: a refused load raises the flag and leaves the pending ratio alone
  p_refuse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !ratio_ok(req)) |=> (err && $stable(pend)));
  // R6: the pending ratio is legal at all times
  p_pend_legal_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ratio_ok(pend));
endmodule

// File: rtl/pswal_prescaler.sv
module pswal_prescaler
  import pswal_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reload,
  input  logic [PCW-1:0] span,
  output logic           tick
);
  logic [PCW-1:0] cnt;
  logic [PCW-1:0] cnt_nx;

  always_comb begin
    tick   = (cnt == '0);
    cnt_nx = reload ? span : cnt - PCW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= base_of(RATIO_RST.sel) - PCW'(1);
    else        cnt <= cnt_nx;
  end

  // R2: the modulus count never exceeds the largest modulus 65 (count 64)
  p_cnt_cap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= PCW'(1 << (PCW-1)));
  // R2: without a reload the count steps down by one
  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!reload && !tick) |=> (cnt == $past(cnt) - PCW'(1)));
endmodule

// File: rtl/pswal_swallow.sv
module pswal_swallow
  import pswal_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hold,
  input  logic            tick,
  input  ratio_t          pend,
  output logic            wrap,
  output logic [SELW-1:0] nx_sel,
  output logic            nx_plus
);
  logic [SELW-1:0] sel_q;
  logic [AW-1:0]   a_cnt, a_nx;
  logic [BW-1:0]   b_cnt, b_nx;
  logic            reload;

  always_comb begin
    wrap   = tick && !hold && (b_cnt == BW'(1));
    reload = hold || wrap;
    nx_sel = sel_q;
    a_nx   = a_cnt;
    b_nx   = b_cnt;
    if (reload) begin
      nx_sel = pend.sel;
      a_nx   = pend.a;
      b_nx   = pend.b;
    end else if (tick) begin
      b_nx = b_cnt - BW'(1);
      a_nx = (a_cnt != '0) ? a_cnt - AW'(1) : '0;
    end
    nx_plus = (a_nx != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= RATIO_RST.sel;
      a_cnt <= RATIO_RST.a;
      b_cnt <= RATIO_RST.b;
    end else begin
      sel_q <= nx_sel;
      a_cnt <= a_nx;
      b_cnt <= b_nx;
    end
  end

  // R4: swallowed cycles never outnumber the remaining prescaler cycles
  p_a_le_b_r4: assert property (@(posedge clk) disable iff (!rst_n)
    {{(BW-AW){1'b0}}, a_cnt} <= b_cnt);
  // R1: the main counter never reaches zero
  p_b_live_r1: assert property (@(posedge clk) disable iff (!rst_n)
    b_cnt != '0);
endmodule

// File: rtl/pswal_divider.sv
module pswal_divider
  import pswal_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [SELW-1:0] mod_sel,
  input  logic [BW-1:0]   b_in,
  input  logic [AW-1:0]   a_in,
  input  logic            cfg_load,
  input  logic            cnt_hold,
  output logic            div_pulse,
  output logic            cfg_err
);
  logic [1:0]      rsync;
  logic            rst_n_s;
  ratio_t          req, pend;
  logic            tick, wrap, nx_plus;
  logic [SELW-1:0] nx_sel;
  logic [PCW-1:0]  span;
  logic            pre_reload;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync <= '0;
    else        rsync <= {rsync[0], 1'b1};
  end
  assign rst_n_s = rsync[1];

  always_comb begin
    req        = '{sel: mod_sel, b: b_in, a: a_in};
    span       = base_of(nx_sel) - PCW'(1) + PCW'(nx_plus);
    pre_reload = cnt_hold || tick;
  end

  pswal_cfg u_cfg (
    .clk(clk), .rst_n(rst_n_s), .load(cfg_load), .req(req),
    .pend(pend), .err(cfg_err)
  );

  pswal_prescaler u_pre (
    .clk(clk), .rst_n(rst_n_s), .reload(pre_reload), .span(span),
    .tick(tick)
  );

  pswal_swallow u_swl (
    .clk(clk), .rst_n(rst_n_s), .hold(cnt_hold), .tick(tick),
    .pend(pend), .wrap(wrap), .nx_sel(nx_sel), .nx_plus(nx_plus)
  );

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) div_pulse <= 1'b0;
    else          div_pulse <= wrap;
  end

  // R3: the output pulse lasts one cycle
  p_pulse_single_r3: assert property (@(posedge clk) disable iff (!rst_n_s)
    div_pulse |=> !div_pulse);
  // R7: holding the counters suppresses the pulse
  p_hold_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n_s)
    cnt_hold |=> !div_pulse);
endmodule

// File: tb/tb_pswal_divider.sv
module tb_pswal_divider;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  mod_sel;
  logic [12:0] b_in;
  logic [5:0]  a_in;
  logic        cfg_load;
  logic        cnt_hold;
  logic        div_pulse;
  logic        cfg_err;

  int checks = 0;
  int fails  = 0;

  localparam int NV = 8;
  // sel, B, A, expected N = B*(8<<sel)+A
  localparam int VSEL[NV] = '{0, 0, 1, 2, 3, 1, 3, 2};
  localparam int VB[NV]   = '{3, 3, 10, 20, 4, 100, 63, 7};
  localparam int VA[NV]   = '{0, 3, 5, 0, 4, 63, 63, 1};
  localparam int VN[NV]   = '{24, 27, 165, 640, 260, 1663, 4095, 225};

  always #2 clk = ~clk;

  pswal_divider dut (
    .clk(clk), .rst_n(rst_n), .mod_sel(mod_sel), .b_in(b_in), .a_in(a_in),
    .cfg_load(cfg_load), .cnt_hold(cnt_hold), .div_pulse(div_pulse),
    .cfg_err(cfg_err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_load(input int sel, input int b, input int a);
    @(negedge clk);
    mod_sel  = 2'(sel);
    b_in     = 13'(b);
    a_in     = 6'(a);
    cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
  endtask

  task automatic wait_pulse();
    do @(negedge clk); while (!div_pulse);
  endtask

  task automatic meas(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!div_pulse);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    int n;
    int wide;
    rst_n = 1'b0; mod_sel = '0; b_in = '0; a_in = '0;
    cfg_load = 1'b0; cnt_hold = 1'b0;
    repeat (4) @(negedge clk);
    chk(div_pulse == 1'b0, "R8 pulse in reset", int'(div_pulse), 0);
    chk(cfg_err == 1'b0, "R8 err in reset", int'(cfg_err), 0);
    rst_n = 1'b1;
    wait_pulse();
    meas(n);
    chk(n == 24, "R8 default ratio", n, 24);

    // table walk: R1 ratio, R2 select, R4 swallow extremes, R3 width
    for (int i = 0; i < NV; i++) begin
      do_load(VSEL[i], VB[i], VA[i]);
      wait_pulse();
      meas(n);
      chk(n == VN[i], "R1 R2 R4 table ratio", n, VN[i]);
      @(negedge clk);
      chk(div_pulse == 1'b0, "R3 pulse width", int'(div_pulse), 0);
    end

    // R5: load mid-period leaves the running period at 225
    wait_pulse();
    n = 0;
    do begin
      @(negedge clk); n++;
      if (n == 5) begin
        mod_sel = 2'd0; b_in = 13'd4; a_in = 6'd2; cfg_load = 1'b1;
      end else cfg_load = 1'b0;
    end while (!div_pulse);
    chk(n == 225, "R5 old period kept", n, 225);
    meas(n);
    chk(n == 34, "R5 new ratio after reload", n, 34);

    // R6: refused loads
    do_load(0, 5, 9);
    chk(cfg_err == 1'b1, "R6 err on B<A", int'(cfg_err), 1);
    wait_pulse(); meas(n);
    chk(n == 34, "R6 ratio kept after B<A", n, 34);
    do_load(1, 2, 0);
    chk(cfg_err == 1'b1, "R6 err on B<3", int'(cfg_err), 1);
    wait_pulse(); meas(n);
    chk(n == 34, "R6 ratio kept after B<3", n, 34);
    do_load(0, 6, 0);
    chk(cfg_err == 1'b0, "R6 err cleared", int'(cfg_err), 0);
    wait_pulse(); meas(n);
    chk(n == 48, "R6 legal load applies", n, 48);

    // R7: hold, load inside hold, release
    @(negedge clk); cnt_hold = 1'b1;
    do_load(1, 5, 2);
    n = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (div_pulse) n++;
    end
    chk(n == 0, "R7 no pulse under hold", n, 0);
    cnt_hold = 1'b0;
    meas(n);
    chk(n == 82, "R7 first pulse after release", n, 82);

    // R9: largest B with A=63, applied through hold
    @(negedge clk); cnt_hold = 1'b1;
    do_load(0, 8191, 63);
    @(negedge clk); cnt_hold = 1'b0;
    meas(n);
    chk(n == 65591, "R9 top of B range", n, 65591);

    // R1: random legal settings
    for (int r = 0; r < 5; r++) begin
      int s, b, a, lim;
      s = int'($urandom % 4);
      b = 3 + int'($urandom % 38);
      lim = (b < 63) ? b : 63;
      a = int'($urandom % (lim + 1));
      wide = b * (8 << s) + a;
      do_load(s, b, a);
      wait_pulse(); meas(n);
      chk(n == wide, "R1 random ratio", n, wide);
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule